// File: doc/BRIEF.md
# Capture-Compare Timer Channel

This block is a single 16-bit timer channel. An up counter advances on a tick taken from one of eight sources: the system clock divided by 1, 2, 4 or 8, or one of four external clock pins. Two general registers sit beside the counter. Software sets each one, at run time and on its own, to work either as an output compare or as an input capture. A compare register watches the counter and acts on its own output pin when the two are equal. A capture register takes a snapshot of the counter when its input pin shows the selected edge.

On top of this the channel can clear its counter on an event of either general register. It also has a PWM mode, in which the first register raises the output and the second lowers it. A buffer register is tied to the first general register. While capturing, it keeps the previous snapshot. While comparing, it holds the next compare value, which is loaded at each match. All state is read and written over a simple 16-bit register bus with a 3-bit address. Reads are combinational. A write takes effect at the next clock edge.

Top module: `capTimerChan`

## Requirements
- R1: After reset every register reads 0, the counter is stopped and both compare outputs are 0.
- R2: CTRL (address 0) bit 7 enables counting, and bits 2:0 select the tick source. Codes 0 to 3 advance the counter once every 1, 2, 4 or 8 system clocks, from a prescaler that runs freely from reset. With bit 7 clear the counter holds its value.
- R3: Codes 4 to 7 of CTRL bits 2:0 select external pins 0 to 3. Each pin passes through two synchronizing flops, and only a rising edge advances the counter, in the cycle after the edge leaves the synchronizer. The unselected pins have no effect.
- R4: IOCFG (address 1) holds 3 bits per general register: bits 2:0 for register 0 and bits 6:4 for register 1, each laid out as {capture, code}. When the capture bit is 0 and a tick comes while the counter equals the register, the pin is changed by the code: 1 drives 0, 2 drives 1, 3 toggles, and 0 leaves the pin alone.
- R5: When the capture bit is 1, code bit 0 enables capture on rising edges and code bit 1 enables capture on falling edges. Both inputs use the same two-flop synchronizer as the clock pins. On a capture the register loads the counter value. Capture does not need the counter to be running.
- R6: CTRL bits 4:3 select the clear source: 1 for an event of register 0 and 2 for an event of register 1. On such an event the counter goes to 0 instead of incrementing. Codes 0 and 3 never clear.
- R7: With CTRL bit 5 set, output 0 goes to 1 on a register 0 match and to 0 on a register 1 match. When both match in the same tick, 0 wins. The IOCFG code of register 0 is ignored in this mode.
- R8: With CTRL bit 6 set and register 0 in capture mode, each capture moves the old register 0 value into BUF (address 6).
- R9: With CTRL bit 6 set and register 0 in compare mode, each match loads BUF into register 0.
- R10: In STATUS (address 2), bits 0 and 1 are the event flags of registers 0 and 1. A flag is set by a match or a capture. A write clears a flag where the written bit is 0 and leaves it where the bit is 1. A set in the same cycle wins over the clear.
- R11: STATUS bit 2 is set when a tick moves the counter from 0xFFFF to 0. It is not set when a clear or a bus write to the counter happens in that cycle, and it is cleared by writing 0, like the event flags.
- R12: A bus write to COUNT (address 3) takes priority over the increment and over the clear in the same cycle.
- R13: COUNT, GR0 (address 4), GR1 (address 5) and BUF (address 6) can be read and written as full 16-bit values. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 3 | Register address |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Combinational read data of the addressed register |
| extClk | input | 4 | External clock pins |
| capIn | input | 2 | Capture input pins, one per general register |
| cmpOut | output | 2 | Compare output pins, one per general register |

## Verification
The hardest case to reach from the ports is two events landing on one edge. Examples are a counter write in the tick that would wrap or clear, a flag write-0 in the cycle a new event arrives, and both PWM registers matching on the same tick. The stimulus gets there by setting the general registers and the clear source so that matches recur every few cycles at a divide-by-one tick. Bus writes and pin edges are then swept across that period, so many edges carry more than one event. A behavioural reference model steps through every clock and compares the addressed register and both output pins on every cycle.

// File: rtl/capTimerPkg.sv
package capTimerPkg;
  localparam int TMR_W     = 16;
  localparam int GR_N      = 2;
  localparam int EXT_N     = 4;
  localparam int ADDR_W    = 3;
  localparam int DIV_SEL_W = 2;
  localparam int IO_STRIDE = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_IOCFG = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CNT   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_GR0   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_BUF   = ADDR_GR0 + ADDR_W'(GR_N);

  localparam logic [1:0] ACT_NONE = 2'd0;
  localparam logic [1:0] ACT_LOW  = 2'd1;
  localparam logic [1:0] ACT_HIGH = 2'd2;
  localparam logic [1:0] ACT_TOG  = 2'd3;

  // control register layout, MSB first (bit 7 .. bit 0)
  typedef struct packed {
    logic                 run;
    logic                 bufEn;
    logic                 pwmEn;
    logic [1:0]           clrSel;
    logic [DIV_SEL_W:0]   clkSel;
  } chanCfgT;

  typedef struct packed {
    logic       isCap;
    logic [1:0] act;
  } grCfgT;

  localparam int CFG_W   = $bits(chanCfgT);
  localparam int GRCFG_W = $bits(grCfgT);

  // strobes from control to datapath
  typedef struct packed {
    logic            tick;
    logic [GR_N-1:0] match;
    logic [GR_N-1:0] capture;
    logic            clear;
    logic            wrap;
  } strobeT;
endpackage

// File: rtl/capTimerCtrl.sv
module capTimerCtrl
  import capTimerPkg::*;
#(
  parameter int SYNC_N  = 2,
  parameter int PRESC_W = 3
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       run,
  input  logic [DIV_SEL_W:0]         clkSel,
  input  logic [1:0]                 clrSel,
  input  grCfgT [GR_N-1:0]           grCfg,
  input  logic [EXT_N-1:0]           extClk,
  input  logic [GR_N-1:0]            capIn,
  input  logic [TMR_W-1:0]           cnt,
  input  logic [GR_N-1:0][TMR_W-1:0] gr,
  output strobeT                     stb
);
  logic [PRESC_W-1:0]            presc;
  logic [SYNC_N:0][EXT_N-1:0]    extPipe;
  logic [SYNC_N:0][GR_N-1:0]     capPipe;
  logic [EXT_N-1:0]              extRise;
  logic [GR_N-1:0]               capRise, capFall;
  logic [PRESC_W-1:0]            divMask;
  logic                          intTick, extTick, tick;
  logic [GR_N-1:0]               matchV, capV;
  logic                          clrHit;

  // free-running prescaler (R2)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) presc <= '0;
    else       presc <= presc + PRESC_W'(1);
  end

  // synchronizers with one extra stage kept for edge detection (R3, R5)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPipe <= '0;
      capPipe <= '0;
    end else begin
      extPipe <= {extPipe[SYNC_N-1:0], extClk};
      capPipe <= {capPipe[SYNC_N-1:0], capIn};
    end
  end

  assign extRise = extPipe[SYNC_N-1] & ~extPipe[SYNC_N];
  assign capRise = capPipe[SYNC_N-1] & ~capPipe[SYNC_N];
  assign capFall = ~capPipe[SYNC_N-1] & capPipe[SYNC_N];

  assign divMask = PRESC_W'((1 << clkSel[DIV_SEL_W-1:0]) - 1);
  assign intTick = (presc & divMask) == divMask;
  assign extTick = extRise[clkSel[DIV_SEL_W-1:0]];
  assign tick    = run & (clkSel[DIV_SEL_W] ? extTick : intTick);

  // per general register event detection (R4, R5)
  for (genvar g = 0; g < GR_N; g++) begin : genEvt
    assign matchV[g] = tick & ~grCfg[g].isCap & (cnt == gr[g]);
    assign capV[g]   = grCfg[g].isCap &
                       ((grCfg[g].act[0] & capRise[g]) | (grCfg[g].act[1] & capFall[g]));
  end

  // clear source select (R6)
  always_comb begin
    clrHit = 1'b0;
    for (int i = 0; i < GR_N; i++) begin
      if (clrSel == 2'(i + 1)) clrHit = matchV[i] | capV[i];
    end
  end

  always_comb begin
    stb.tick    = tick;
    stb.match   = matchV;
    stb.capture = capV;
    stb.clear   = clrHit;
    stb.wrap    = tick & (&cnt) & ~clrHit;
  end
endmodule

// File: rtl/capTimerDp.sv
module capTimerDp
  import capTimerPkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busWrEn,
  input  logic [TMR_W-1:0]           busWrData,
  output logic [TMR_W-1:0]           busRdData,
  input  strobeT                     stb,
  output chanCfgT                    cfg,
  output grCfgT [GR_N-1:0]           grCfg,
  output logic [TMR_W-1:0]           cnt,
  output logic [GR_N-1:0][TMR_W-1:0] gr,
  output logic [GR_N-1:0]            evtFlag,
  output logic                       ovfFlag,
  output logic [GR_N-1:0]            cmpOut
);
  localparam int REG_N = 1 << ADDR_W;

  logic [REG_N-1:0] wrHit;
  logic [TMR_W-1:0] bufReg;
  logic [TMR_W-1:0] ioRd;
  logic             flagKeepAll;

  always_comb begin
    wrHit = '0;
    if (busWrEn) wrHit[busAddr] = 1'b1;
  end

  assign flagKeepAll = ~wrHit[ADDR_STAT];

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg   <= '0;
      grCfg <= '0;
    end else begin
      if (wrHit[ADDR_CTRL]) cfg <= chanCfgT'(busWrData[CFG_W-1:0]);
      if (wrHit[ADDR_IOCFG]) begin
        for (int g = 0; g < GR_N; g++)
          grCfg[g] <= grCfgT'(busWrData[IO_STRIDE*g +: GRCFG_W]);
      end
    end
  end

  // counter: bus write beats clear beats increment (R12, R6, R2)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (wrHit[ADDR_CNT])  cnt <= busWrData;
    else if (stb.clear)        cnt <= '0;
    else if (stb.tick)         cnt <= cnt + TMR_W'(1);
  end

  // overflow flag, suppressed by a same-cycle counter write (R11)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfFlag <= 1'b0;
    else       ovfFlag <= (stb.wrap & ~wrHit[ADDR_CNT]) |
                          (ovfFlag & (flagKeepAll | busWrData[GR_N]));
  end

  // general registers, event flags and outputs (R4, R5, R7, R9, R10)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gr      <= '0;
      evtFlag <= '0;
      cmpOut  <= '0;
    end else begin
      for (int g = 0; g < GR_N; g++) begin
        if (wrHit[ADDR_GR0 + ADDR_W'(g)])       gr[g] <= busWrData;
        else if (stb.capture[g])                gr[g] <= cnt;
        else if (g == 0 && cfg.bufEn && stb.match[g]) gr[g] <= bufReg;

        evtFlag[g] <= stb.match[g] | stb.capture[g] |
                      (evtFlag[g] & (flagKeepAll | busWrData[g]));

        if (g == 0 && cfg.pwmEn) begin
          if (stb.match[1])      cmpOut[g] <= 1'b0;
          else if (stb.match[0]) cmpOut[g] <= 1'b1;
        end else if (stb.match[g]) begin
          case (grCfg[g].act)
            ACT_LOW:  cmpOut[g] <= 1'b0;
            ACT_HIGH: cmpOut[g] <= 1'b1;
            ACT_TOG:  cmpOut[g] <= ~cmpOut[g];
            default:  cmpOut[g] <= cmpOut[g];
          endcase
        end
      end
    end
  end

  // buffer register (R8)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         bufReg <= '0;
    else if (wrHit[ADDR_BUF])          bufReg <= busWrData;
    else if (cfg.bufEn && stb.capture[0]) bufReg <= gr[0];
  end

  // read path (R13)
  for (genvar g = 0; g < GR_N; g++) begin : genIoRd
    assign ioRd[IO_STRIDE*g +: IO_STRIDE] = {{(IO_STRIDE-GRCFG_W){1'b0}}, grCfg[g]};
  end
  assign ioRd[TMR_W-1:IO_STRIDE*GR_N] = '0;

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_CTRL:  busRdData[CFG_W-1:0] = cfg;
      ADDR_IOCFG: busRdData = ioRd;
      ADDR_STAT:  busRdData[GR_N:0] = {ovfFlag, evtFlag};
      ADDR_CNT:   busRdData = cnt;
      ADDR_BUF:   busRdData = bufReg;
      default: begin
        for (int i = 0; i < GR_N; i++)
          if (busAddr == ADDR_GR0 + ADDR_W'(i)) busRdData = gr[i];
      end
    endcase
  end
endmodule

// File: rtl/capTimerChan.sv
module capTimerChan
  import capTimerPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        busAddr,
  input  logic              busWrEn,
  input  logic [15:0]       busWrData,
  output logic [15:0]       busRdData,
  input  logic [3:0]        extClk,
  input  logic [1:0]        capIn,
  output logic [1:0]        cmpOut
);
  strobeT                     stbW;
  chanCfgT                    cfgW;
  grCfgT [GR_N-1:0]           grCfgW;
  logic [TMR_W-1:0]           cntVal;
  logic [GR_N-1:0][TMR_W-1:0] grVal;
  logic [GR_N-1:0]            flagW;
  logic                       ovfW;

  capTimerCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .run    (cfgW.run),
    .clkSel (cfgW.clkSel),
    .clrSel (cfgW.clrSel),
    .grCfg  (grCfgW),
    .extClk (extClk),
    .capIn  (capIn),
    .cnt    (cntVal),
    .gr     (grVal),
    .stb    (stbW)
  );

  capTimerDp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .stb       (stbW),
    .cfg       (cfgW),
    .grCfg     (grCfgW),
    .cnt       (cntVal),
    .gr        (grVal),
    .evtFlag   (flagW),
    .ovfFlag   (ovfW),
    .cmpOut    (cmpOut)
  );
endmodule

// File: rtl/capTimerChk.sv
module capTimerChk
  import capTimerPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [TMR_W-1:0]  busWrData,
  input logic [TMR_W-1:0]  cnt,
  input logic [TMR_W-1:0]  gr1,
  input strobeT            stb,
  input logic              run,
  input logic              pwmEn,
  input logic              ovfFlag,
  input logic              flag0,
  input logic              pwmOut
);
  logic cntWr, gr1Wr;
  assign cntWr = busWrEn && (busAddr == ADDR_CNT);
  assign gr1Wr = busWrEn && (busAddr == ADDR_GR0 + 3'd1);

  assert_no_tick_stopped_R2: assert property (@(posedge clk) disable iff (!rstN)
    !run |-> !stb.tick);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tick && !stb.clear && !cntWr && cnt != '1) |=> cnt == TMR_W'($past(cnt) + 1'b1));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clear && !cntWr) |=> cnt == '0);

  assert_wrap_ovf_R11: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrap && !cntWr) |=> ovfFlag);

  assert_bus_count_R12: assert property (@(posedge clk) disable iff (!rstN)
    cntWr |=> cnt == $past(busWrData));

  assert_pwm_reset_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pwmEn && stb.match[1]) |=> !pwmOut);

  assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.match[0] || stb.capture[0]) |=> flag0);

  assert_capture_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capture[1] && !gr1Wr) |=> gr1 == $past(cnt));
endmodule

bind capTimerChan capTimerChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWrData (busWrData),
  .cnt       (cntVal),
  .gr1       (grVal[1]),
  .stb       (stbW),
  .run       (cfgW.run),
  .pwmEn     (cfgW.pwmEn),
  .ovfFlag   (ovfW),
  .flag0     (flagW[0]),
  .pwmOut    (cmpOut[0])
);

// File: tb/sim_capTimerChan.sv
module sim_capTimerChan;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = 3'd3;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic [3:0]  extClk = '0;
  logic [1:0]  capIn = '0;
  logic [1:0]  cmpOut;

  int    errs = 0;
  int    checks = 0;
  bit    finished = 1'b0;
  string curTag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  capTimerChan u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .extClk(extClk),
    .capIn(capIn), .cmpOut(cmpOut)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] mCnt, mBuf;
  logic [15:0] mGr [2];
  logic [7:0]  mCtrl;
  logic        mIsCap [2];
  logic [1:0]  mAct [2];
  logic [1:0]  mFlag, mOut;
  logic        mOvf;
  logic [3:0]  e1, e2, e3;
  logic [1:0]  c1, c2, c3;
  int          mPresc;

  always @(posedge clk or negedge rstN) begin : refModel
    logic tick, clr, wrap, wrC, wrS;
    logic mat [2];
    logic cap [2];
    logic [15:0] nGr [2];
    logic [1:0] nOut, nFlag;
    int div;
    if (!rstN) begin
      mCnt = 0; mBuf = 0; mGr[0] = 0; mGr[1] = 0; mCtrl = 0;
      mIsCap[0] = 0; mIsCap[1] = 0; mAct[0] = 0; mAct[1] = 0;
      mFlag = 0; mOut = 0; mOvf = 0; e1 = 0; e2 = 0; e3 = 0;
      c1 = 0; c2 = 0; c3 = 0; mPresc = 0;
    end else begin
      div = 1 << mCtrl[1:0];
      if (!mCtrl[7])     tick = 1'b0;
      else if (mCtrl[2]) tick = e2[mCtrl[1:0]] & ~e3[mCtrl[1:0]];
      else               tick = (mPresc % div) == div - 1;
      for (int i = 0; i < 2; i++) begin
        mat[i] = tick && !mIsCap[i] && mCnt == mGr[i];
        cap[i] = mIsCap[i] && ((mAct[i][0] && c2[i] && !c3[i]) ||
                               (mAct[i][1] && !c2[i] && c3[i]));
      end
      clr = (mCtrl[4:3] == 2'd1 && (mat[0] || cap[0])) ||
            (mCtrl[4:3] == 2'd2 && (mat[1] || cap[1]));
      wrC  = busWrEn && busAddr == 3'd3;
      wrS  = busWrEn && busAddr == 3'd2;
      wrap = tick && mCnt == 16'hFFFF && !clr;
      nOut = mOut;
      for (int i = 0; i < 2; i++) begin
        if (i == 0 && mCtrl[5]) begin
          if (mat[1])      nOut[0] = 1'b0;
          else if (mat[0]) nOut[0] = 1'b1;
        end else if (mat[i]) begin
          if (mAct[i] == 2'd1)      nOut[i] = 1'b0;
          else if (mAct[i] == 2'd2) nOut[i] = 1'b1;
          else if (mAct[i] == 2'd3) nOut[i] = ~mOut[i];
        end
        if (busWrEn && busAddr == 3'(4 + i)) nGr[i] = busWrData;
        else if (cap[i])                      nGr[i] = mCnt;
        else if (i == 0 && mCtrl[6] && mat[0]) nGr[i] = mBuf;
        else                                  nGr[i] = mGr[i];
        nFlag[i] = mat[i] || cap[i] || (mFlag[i] && (!wrS || busWrData[i]));
      end
      if (busWrEn && busAddr == 3'd6) mBuf = busWrData;
      else if (mCtrl[6] && cap[0])    mBuf = mGr[0];
      mOvf = (wrap && !wrC) || (mOvf && (!wrS || busWrData[2]));
      if (wrC)       mCnt = busWrData;
      else if (clr)  mCnt = 0;
      else if (tick) mCnt = mCnt + 16'd1;
      if (busWrEn && busAddr == 3'd0) mCtrl = busWrData[7:0];
      if (busWrEn && busAddr == 3'd1) begin
        mAct[0] = busWrData[1:0]; mIsCap[0] = busWrData[2];
        mAct[1] = busWrData[5:4]; mIsCap[1] = busWrData[6];
      end
      mGr[0] = nGr[0]; mGr[1] = nGr[1];
      mFlag = nFlag; mOut = nOut;
      e3 = e2; e2 = e1; e1 = extClk;
      c3 = c2; c2 = c1; c1 = capIn;
      mPresc++;
    end
  end

  function automatic logic [15:0] mRead(input logic [2:0] a);
    case (a)
      3'd0: return {8'h00, mCtrl};
      3'd1: return {9'd0, mIsCap[1], mAct[1], 1'b0, mIsCap[0], mAct[0]};
      3'd2: return {13'd0, mOvf, mFlag};
      3'd3: return mCnt;
      3'd4: return mGr[0];
      3'd5: return mGr[1];
      3'd6: return mBuf;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(curTag, busRdData, mRead(busAddr));
      chk(curTag, {14'd0, cmpOut}, {14'd0, mOut});
    end
  end

  task automatic drive(input logic [2:0] a, input logic we, input logic [15:0] d);
    @(posedge clk); #1;
    busAddr = a; busWrEn = we; busWrData = d;
  endtask
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    drive(a, 1'b1, d);
    drive(3'd3, 1'b0, 16'h0);
  endtask
  task automatic idle(input int n);
    repeat (n) drive(3'd3, 1'b0, 16'h0);
  endtask
  task automatic look(input logic [2:0] a);
    drive(a, 1'b0, 16'h0);
  endtask
  task automatic pins(input logic [3:0] e, input logic [1:0] c);
    @(posedge clk); #1;
    extClk = e; capIn = c;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] held;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 / R13: reset values at every address
    curTag = "R1";
    for (int a = 0; a < 8; a++) begin
      look(3'(a));
      @(negedge clk);
      chk("R1", busRdData, 16'h0000);
    end
    chk("R1", {14'd0, cmpOut}, 16'h0000);

    // R13: full-width register access
    curTag = "R13";
    wr(3'd4, 16'hA5A5); look(3'd4); @(negedge clk); chk("R13", busRdData, 16'hA5A5);
    wr(3'd6, 16'h0F0F); look(3'd6); @(negedge clk); chk("R13", busRdData, 16'h0F0F);
    wr(3'd5, 16'h5A5A); look(3'd5); @(negedge clk); chk("R13", busRdData, 16'h5A5A);
    look(3'd7); @(negedge clk); chk("R13", busRdData, 16'h0000);

    // R2: internal dividers, then stop
    curTag = "R2";
    for (int k = 0; k < 4; k++) begin
      wr(3'd0, 16'(8'h80 | k));
      idle(24);
    end
    wr(3'd0, 16'h0001);
    @(negedge clk); held = busRdData;
    idle(6);
    @(negedge clk); chk("R2", busRdData, held);

    // R3: external clocks, selected pin and its neighbours toggled
    curTag = "R3";
    for (int j = 0; j < 4; j++) begin
      wr(3'd0, 16'(8'h84 + j));
      for (int p = 1; p <= 4; p++) begin
        pins(4'((1 << j) | (p[0] ? 4'b1010 : 4'b0101)), 2'b00);
        idle(p);
        pins(p[1] ? 4'b1111 : 4'b0000, 2'b00);
        idle(p);
        pins(4'b0000, 2'b00);
        idle(p + 1);
      end
    end

    // R4 / R6: compare actions with clear on register 1
    curTag = "R4";
    wr(3'd0, 16'h0000); wr(3'd3, 16'h0000);
    wr(3'd4, 16'd10); wr(3'd5, 16'd20);
    wr(3'd1, 16'h0023);
    wr(3'd0, 16'h0090);
    idle(70);
    wr(3'd1, 16'h0013);
    idle(50);
    curTag = "R6";
    wr(3'd0, 16'h0088);
    idle(30);

    // R5: capture edges while running and while stopped
    curTag = "R5";
    wr(3'd0, 16'h0080);
    wr(3'd1, 16'h0075);
    for (int p = 0; p < 3; p++) begin
      pins(4'h0, 2'b01); idle(3 + p);
      pins(4'h0, 2'b11); idle(5);
      pins(4'h0, 2'b10); idle(4);
      pins(4'h0, 2'b00); idle(6);
      look(3'd4); look(3'd5);
    end
    wr(3'd1, 16'h0056);
    wr(3'd0, 16'h0000);
    pins(4'h0, 2'b11); idle(5); pins(4'h0, 2'b00); idle(5);
    look(3'd4); look(3'd5);

    // R6: clear on a capture of register 0
    curTag = "R6";
    wr(3'd1, 16'h0005);
    wr(3'd0, 16'h0088);
    for (int p = 0; p < 4; p++) begin
      idle(7 + p); pins(4'h0, 2'b01); idle(3); pins(4'h0, 2'b00);
    end
    idle(5);

    // R8: buffered capture
    curTag = "R8";
    wr(3'd0, 16'h00C0);
    for (int p = 0; p < 4; p++) begin
      idle(5 + 2 * p); pins(4'h0, 2'b01); idle(4);
      look(3'd6); look(3'd4); pins(4'h0, 2'b00);
    end

    // R9: buffered compare
    curTag = "R9";
    wr(3'd0, 16'h0000); wr(3'd3, 16'h0000);
    wr(3'd1, 16'h0003);
    wr(3'd4, 16'd5); wr(3'd6, 16'd15);
    wr(3'd0, 16'h00C8);
    idle(40); look(3'd4); look(3'd6); idle(4);

    // R7: PWM with clear on register 1, then the tie case
    curTag = "R7";
    wr(3'd0, 16'h0000); wr(3'd3, 16'h0000);
    wr(3'd1, 16'h0003);
    wr(3'd4, 16'd4); wr(3'd5, 16'd9);
    wr(3'd0, 16'h00B0);
    idle(40);
    wr(3'd4, 16'd9);
    idle(30);
    @(negedge clk); chk("R7", {15'd0, cmpOut[0]}, 16'h0000);

    // R12: counter write while running
    curTag = "R12";
    wr(3'd0, 16'h0080);
    wr(3'd3, 16'h1234);
    @(negedge clk); chk("R12", busRdData, 16'h1234);
    @(negedge clk); chk("R12", busRdData, 16'h1235);
    wr(3'd5, 16'd7); wr(3'd1, 16'h0000); wr(3'd0, 16'h0090); wr(3'd3, 16'h0000);
    for (int p = 0; p < 8; p++) begin
      idle(p + 2);
      wr(3'd3, 16'(16'd3 + p));
    end
    idle(10);

    // R11 / R10: wrap sets overflow, write-0 clears, write-1 keeps
    curTag = "R11";
    wr(3'd0, 16'h0000); wr(3'd2, 16'h0000);
    wr(3'd3, 16'hFFFE);
    wr(3'd0, 16'h0080);
    idle(4);
    look(3'd2);
    @(negedge clk); chk("R11", busRdData & 16'h0004, 16'h0004);
    curTag = "R10";
    wr(3'd2, 16'h0007); look(3'd2);
    @(negedge clk); chk("R10", busRdData & 16'h0004, 16'h0004);
    wr(3'd2, 16'h0003); look(3'd2);
    @(negedge clk); chk("R10", busRdData & 16'h0004, 16'h0000);
    wr(3'd1, 16'h0003); wr(3'd4, 16'd2); wr(3'd5, 16'd5);
    wr(3'd0, 16'h0090);
    for (int p = 0; p < 10; p++) begin
      idle(p % 3);
      wr(3'd2, 16'(p % 4));
      look(3'd2);
    end
    idle(8);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule